// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external 256K-word by 16-bit asynchronous static RAM. The host hands it one access at a time over a valid/ready handshake: a word address, a write flag, write data and a two-bit byte-lane mask. The controller drives the memory's address, two chip selects of opposite polarity, write and output enables, the two byte-lane enables and a split tri-state data bus. It returns read data with a one-cycle valid pulse.

All memory strobes come from registers, so they only move on clock edges. Every pulse width and wait is a whole number of clock cycles. Each count is the ceiling of a nanosecond parameter divided by the clock period, with a floor of one cycle. Writes are strobed by the write enable, with output enable held high. Before the controller drives the bus it waits out the memory's output release time. Between accesses the memory is left deselected in standby.

With the default parameters (4 ns clock) the counts are: read cycle 22, write pulse 15 (the larger of the 60 ns pulse and the 35 ns data setup), release wait 8, and a recovery of 1.

Top module: `sram_ctl`

## Requirements
- R1: While idle, `req_ready` is 1 and the memory is in standby: `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_lb_n`=`mem_ub_n`=1, and `mem_dq_oe`=0. This is also the state right after reset.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access has finished.
- R3: During a read the chip is selected, `mem_we_n`=1 and `mem_oe_n`=0. `mem_lb_n` is the inverse of mask bit 0 (data bits 7:0), and `mem_ub_n` is the inverse of mask bit 1 (bits 15:8).
- R4: Read data is captured on the edge that comes N_RC cycles after the accept edge. `rd_valid` is 1 for exactly the one cycle after that edge, and `rd_data` holds the captured word.
- R5: In `rd_data`, a lane whose mask bit is 0 reads as zero.
- R6: During a write, `mem_oe_n` stays 1. `mem_we_n` falls N_HZ cycles after the accept edge, together with `mem_dq_oe` rising. It stays low for max(N_WP, N_DW) cycles.
- R7: `mem_addr` is stable for the whole access, and in particular while `mem_we_n` is low.
- R8: A write changes only the lanes whose mask bit is 1. The other lane of the word keeps its value.
- R9: From accept to the return of `req_ready`, a write takes N_HZ + pulse + recovery cycles, and that total is at least N_RC. The data bus is released when the chip is deselected.
- R10: The controller never drives the data bus while `mem_oe_n` is 0, or while the memory may still be driving it.
- R11: A mask of 00 still runs a full cycle with both byte enables high. A read then returns zero, and a write leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| mem_addr | output | 18 | Memory address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_out | output | 16 | Data driven onto the bus |
| mem_dq_in | input | 16 | Data read from the bus |

## Verification
Directed accesses come first:
- Full-word writes and reads at the lowest and highest addresses.
- Lower-only and upper-only writes followed by full reads. These separate correct lane masking from a whole-word write.
- Single-lane reads, which show whether disabled lanes are zeroed.
- Mask-00 accesses.

After these come seeded random mixes of reads and writes over a scattered address pool, checked against a reference array.

The memory model returns junk until 85 ns after the address settles. It also keeps driving for about 30 ns after output enable rises. A capture that is one cycle early therefore shows up as wrong data, and a turnaround that is too short shows up as bus overlap.

// File: rtl/sram_ctl_pkg.sv
// Shared types and helpers for the asynchronous SRAM controller.
// Assumes a 16-bit memory split into two 8-bit lanes.
package sram_ctl_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_TURN,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } ctl_state_t;

    // Cycles needed to cover ns at the given clock period, never below one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Down-counter that times each phase of an access.
// Loading N-1 makes zero read true N edges after the load edge.
module sram_ctl_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // Reload on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_ctl_lanes.sv
// Byte-lane data path: holds the outgoing write word and captures
// read data lane by lane, zeroing lanes that are masked off.
module sram_ctl_lanes
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dq_out
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Per-lane write register and masked read capture.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dq_out[l*LANE_W +: LANE_W]  <= '0;
                rd_data[l*LANE_W +: LANE_W] <= '0;
            end else begin
                if (load)
                    dq_out[l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
                if (capture)
                    rd_data[l*LANE_W +: LANE_W] <= mask[l] ? dq_in[l*LANE_W +: LANE_W] : '0;
            end
        end
    end
endmodule

// File: rtl/sram_ctl.sv
// Asynchronous SRAM controller top. Takes one host access at a time and
// sequences registered strobes for a 16-bit asynchronous static RAM.
// Assumes the memory needs T_RC_NS per read, a write-enable pulse of at
// least max(T_WP_NS, T_DW_NS), and releases its bus within T_HZ_NS.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW            = 18,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_RC_NS       = 85,
    parameter int T_WP_NS       = 60,
    parameter int T_DW_NS       = 35,
    parameter int T_HZ_NS       = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int N_RC    = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int N_WP    = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int N_DW    = ns_to_cyc(T_DW_NS, CLK_PERIOD_NS);
    localparam int N_HZ    = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
    localparam int N_PULSE = imax(N_WP, N_DW);
    localparam int N_RD    = imax(N_RC, 2);
    localparam int N_REC   = (N_RC > N_HZ + N_PULSE) ? (N_RC - N_HZ - N_PULSE) : 1;
    localparam int MAXL    = imax(imax(N_RD, N_PULSE), imax(N_HZ, N_REC));
    localparam int CW      = $clog2(MAXL + 1);

    localparam logic [CW-1:0] LD_RD  = CW'(N_RD - 1);
    localparam logic [CW-1:0] LD_HZ  = CW'(N_HZ - 1);
    localparam logic [CW-1:0] LD_PW  = CW'(N_PULSE - 1);
    localparam logic [CW-1:0] LD_REC = CW'(N_REC - 1);

    ctl_state_t       state;
    logic [LANES-1:0] mask_q;
    logic             accept;
    logic             tmr_load;
    logic [CW-1:0]    tmr_val;
    logic             tmr_zero;
    logic             do_capture;

    assign req_ready  = (state == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign do_capture = (state == ST_RD_WAIT) && tmr_zero;

    // Pick the phase length to load on each phase entry.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE:     if (accept) begin
                             tmr_load = 1'b1;
                             tmr_val  = req_write ? LD_HZ : LD_RD;
                         end
            ST_WR_TURN:  if (tmr_zero) begin
                             tmr_load = 1'b1;
                             tmr_val  = LD_PW;
                         end
            ST_WR_PULSE: if (tmr_zero) begin
                             tmr_load = 1'b1;
                             tmr_val  = LD_REC;
                         end
            default:     ;
        endcase
    end

    sram_ctl_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_ctl_lanes u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .wdata   (req_wdata),
        .capture (do_capture),
        .mask    (mask_q),
        .dq_in   (mem_dq_in),
        .rd_data (rd_data),
        .dq_out  (mem_dq_out)
    );

    // Access sequencer: every memory strobe is a register set here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mask_q    <= '0;
            rd_valid  <= 1'b0;
            mem_addr  <= '0;
            mem_cs1_n <= 1'b1;
            mem_cs2   <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    rd_valid <= 1'b0;
                    if (accept) begin
                        mask_q    <= req_mask;
                        mem_addr  <= req_addr;
                        mem_cs1_n <= 1'b0;
                        mem_cs2   <= 1'b1;
                        mem_lb_n  <= ~req_mask[0];
                        mem_ub_n  <= ~req_mask[1];
                        mem_oe_n  <= req_write;
                        state     <= req_write ? ST_WR_TURN : ST_RD_SETUP;
                    end
                end
                ST_RD_SETUP: state <= ST_RD_WAIT;
                ST_RD_WAIT: if (tmr_zero) begin
                    rd_valid  <= 1'b1;
                    mem_cs1_n <= 1'b1;
                    mem_cs2   <= 1'b0;
                    mem_oe_n  <= 1'b1;
                    mem_lb_n  <= 1'b1;
                    mem_ub_n  <= 1'b1;
                    state     <= ST_RD_CAPTURE;
                end
                ST_RD_CAPTURE: begin
                    rd_valid <= 1'b0;
                    state    <= ST_IDLE;
                end
                ST_WR_TURN: if (tmr_zero) begin
                    mem_we_n  <= 1'b0;
                    mem_dq_oe <= 1'b1;
                    state     <= ST_WR_PULSE;
                end
                ST_WR_PULSE: if (tmr_zero) begin
                    mem_we_n <= 1'b1;
                    state    <= ST_WR_RECOVER;
                end
                ST_WR_RECOVER: if (tmr_zero) begin
                    mem_cs1_n <= 1'b1;
                    mem_cs2   <= 1'b0;
                    mem_lb_n  <= 1'b1;
                    mem_ub_n  <= 1'b1;
                    mem_dq_oe <= 1'b0;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker counter: consecutive cycles with write enable low.
    logic [CW-1:0] we_lo_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)
            we_lo_cnt <= '0;
        else if (!mem_we_n) begin
            if (we_lo_cnt != {CW{1'b1}})
                we_lo_cnt <= we_lo_cnt + 1'b1;
        end else
            we_lo_cnt <= '0;
    end

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe)); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready); // R2
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R4
    AST_RD_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> !req_ready); // R4
    AST_WE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (mem_oe_n && mem_dq_oe)); // R6
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (we_lo_cnt >= CW'(N_PULSE))); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr)); // R7
    AST_NO_CONTEND: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> mem_oe_n); // R10

endmodule

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;
    localparam int PER    = 4;
    localparam int N_RC   = (85 + PER - 1) / PER;
    localparam int N_HZ   = (30 + PER - 1) / PER;
    localparam int N_PW   = (60 + PER - 1) / PER;
    localparam int N_REC  = (N_RC > N_HZ + N_PW) ? N_RC - N_HZ - N_PW : 1;
    localparam int REL    = 30 / PER;   // model keeps driving this long

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic req_ready, rd_valid;
    logic [15:0] rd_data, mem_dq_out, mem_dq_in;
    logic [17:0] mem_addr;
    logic mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;

    int total = 0, bad = 0, cyc = 0;

    always #(PER/2) clk = ~clk;

    sram_ctl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
        .mem_ub_n(mem_ub_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(input logic [17:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] m);
        return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
    endfunction

    // ---------------- memory model ----------------
    logic [15:0] mdl [logic [17:0]];
    logic [15:0] refm [logic [17:0]];
    int          acc = 0, hold = 0;
    logic [1:0]  drv_q = '0;
    logic [15:0] word_q = '0;
    logic        prev_rd = 0, prev_we_lo = 0;
    logic [17:0] prev_addr = '0;

    function automatic logic [15:0] mdl_get(input logic [17:0] a);
        return mdl.exists(a) ? mdl[a] : init_word(a);
    endfunction

    // Model behaviour sampled away from the active edge.
    always @(negedge clk) begin
        logic sel, rd_cond;
        sel     = !mem_cs1_n && mem_cs2;
        rd_cond = sel && !mem_oe_n && mem_we_n && (!mem_lb_n || !mem_ub_n);
        if (mem_dq_oe) chk(drv_q == 2'b00, "R10 bus overlap", {30'd0, drv_q}, 0);
        if (sel && !mem_we_n) chk(mem_dq_oe, "R6 data driven while WE low", {31'd0, mem_dq_oe}, 1);
        if (prev_we_lo && !mem_we_n) chk(mem_addr == prev_addr, "R7 address moved while WE low", mem_addr, prev_addr);
        if (sel && prev_we_lo && mem_we_n) begin
            logic [1:0] m;
            m = {!mem_ub_n, !mem_lb_n};
            mdl[mem_addr] = merge(mdl_get(mem_addr), mem_dq_out, m);
        end
        if (rd_cond && prev_rd && mem_addr == prev_addr) acc <= acc + 1;
        else acc <= 0;
        if (rd_cond) begin
            hold  <= REL;
            drv_q <= {!mem_ub_n, !mem_lb_n};
        end else if (hold != 0) hold <= hold - 1;
        else drv_q <= 2'b00;
        word_q     <= mdl_get(mem_addr);
        prev_rd    <= rd_cond;
        prev_we_lo <= sel && !mem_we_n;
        prev_addr  <= mem_addr;
    end

    always_comb begin
        logic valid;
        valid = (acc >= N_RC - 1) && prev_rd;
        mem_dq_in[7:0]  = drv_q[0] ? (valid ? word_q[7:0]  : 8'h3C) : 8'hA5;
        mem_dq_in[15:8] = drv_q[1] ? (valid ? word_q[15:8] : 8'h3C) : 8'hA5;
    end

    // Watchdog: a hang is a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] ref_get(input logic [17:0] a);
        return refm.exists(a) ? refm[a] : init_word(a);
    endfunction

    task automatic start(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] m);
        int k;
        logic [15:0] exp;
        exp = merge(16'h0000, ref_get(a), m);
        start(0, a, 16'h0, m);
        chk(!req_ready, "R2 busy after accept", {31'd0, req_ready}, 0);
        chk(!mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n, "R3 read strobes",
            {28'd0, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n}, 32'h6);
        chk({mem_ub_n, mem_lb_n} == ~m, "R3 read byte enables", {30'd0, mem_ub_n, mem_lb_n}, {30'd0, ~m});
        k = 0;
        while (!rd_valid && k < 100) begin @(negedge clk); k++; end
        chk(k == N_RC, "R4 capture cycle", k, N_RC);
        chk(rd_data == exp, (m == 2'b00) ? "R11 empty-mask read" : "R5 read data", rd_data, exp);
        chk(mem_cs1_n && !mem_cs2 && mem_oe_n, "R1 deselect after read", {29'd0, mem_cs1_n, mem_cs2, mem_oe_n}, 32'h5);
        @(negedge clk);
        chk(!rd_valid, "R4 rd_valid one cycle", {31'd0, rd_valid}, 0);
        chk(req_ready, "R2 ready after read", {31'd0, req_ready}, 1);
    endtask

    task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        int k, first, lows;
        bit oe_bad, addr_bad;
        start(1, a, d, m);
        chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R6 turnaround phase", {29'd0, mem_we_n, mem_oe_n, mem_dq_oe}, 32'h6);
        chk({mem_ub_n, mem_lb_n} == ~m, "R8 write byte enables", {30'd0, mem_ub_n, mem_lb_n}, {30'd0, ~m});
        k = 0; first = -1; lows = 0; oe_bad = 0; addr_bad = 0;
        while (!req_ready && k < 200) begin
            @(negedge clk); k++;
            if (!mem_we_n) begin
                if (first < 0) first = k;
                lows++;
            end
            if (!req_ready && !mem_oe_n) oe_bad = 1;
            if (!req_ready && mem_addr != a) addr_bad = 1;
        end
        chk(first == N_HZ, "R6 WE fall cycle", first, N_HZ);
        chk(lows == N_PW, "R6 WE low width", lows, N_PW);
        chk(!oe_bad, "R6 OE held high", {31'd0, oe_bad}, 0);
        chk(!addr_bad, "R7 address held", {31'd0, addr_bad}, 0);
        chk(k == N_HZ + N_PW + N_REC && k >= N_RC, "R9 write length", k, N_HZ + N_PW + N_REC);
        chk(!mem_dq_oe && mem_cs1_n && !mem_cs2, "R9 bus released", {29'd0, mem_dq_oe, mem_cs1_n, mem_cs2}, 32'h2);
        refm[a] = merge(ref_get(a), d, m);
    endtask

    initial begin
        int seed;
        seed = $urandom(20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready && mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
            "R1 reset standby", {24'd0, req_ready, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 32'hDE);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && mem_cs1_n && !mem_cs2 && !mem_dq_oe, "R1 idle standby", {31'd0, req_ready}, 1);

        // Directed corners
        do_write(18'h00000, 16'h1234, 2'b11);
        do_write(18'h3FFFF, 16'hBEEF, 2'b11);
        do_read(18'h00000, 2'b11);
        do_read(18'h3FFFF, 2'b11);
        do_write(18'h00000, 16'hAAC5, 2'b01);   // R8 lower only
        do_read(18'h00000, 2'b11);
        do_write(18'h3FFFF, 16'h77FF, 2'b10);   // R8 upper only
        do_read(18'h3FFFF, 2'b11);
        do_read(18'h3FFFF, 2'b01);              // R5 lower lane only
        do_read(18'h00000, 2'b10);              // R5 upper lane only
        do_write(18'h00000, 16'hFFFF, 2'b00);   // R11 empty write
        do_read(18'h00000, 2'b11);
        do_read(18'h00000, 2'b00);              // R11 empty read

        // Seeded random mix
        for (int i = 0; i < 150; i++) begin
            logic [17:0] a;
            logic [1:0]  m;
            a = 18'(($urandom % 24) * 18'h2AAB);
            m = 2'($urandom);
            if ($urandom % 2) do_write(a, 16'($urandom), m);
            else do_read(a, m);
        end
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule